// File: doc/BRIEF.md
# Clock-Control Register File with Two-Wire Block-Write Slave

This block is the configuration store of a clock generator. It is a two-wire serial slave with a bank of thirteen byte-wide control registers. The registers hold the settings the clock core acts on. The two-wire bus is sampled on the system clock. SCL and SDA pass through two-flop synchronizers. The slave pulls SDA low through an open-drain output.

A write starts with the slave address and its write bit. Two filler bytes follow; the slave acknowledges both and discards them. The data bytes then fill register 0, register 1 and so on, with no register pointer sent on the bus. A read with the read bit set returns the registers from register 0 onward. Two of the registers hold fixed identification values and cannot be written. The decoded fields are outputs of the block: enable bits for each output, the frequency-source select, a 6-bit table index, the spread controls, a global tristate, a skew code, a divisor code and the M/N values. Defaults load only when the power-up reset is applied.

Top module: `clkCfgSlave`

## Requirements
- R1: After the power-up reset, sdaLowOut is 0 and the outputs show the defaults: freqSwSel=0, tableIdx=0, spreadEn=0, spreadWide=0, allTristate=0, cpuEn=8'hFF, pciEn=8'hFF, fastEn=3'b111, auxEn=5'h1F, skewCode=3'b100, divCode=2'b00, mnSel=0, nVal=0, mVal=0.
- R2: The slave acknowledges an address byte whose upper seven bits equal SLAVE_ADDR (bit 0 is the read flag, 1 = read). On any other address it gives no acknowledge, keeps SDA released and ignores every byte until the next START.
- R3: In a write, the slave acknowledges the first two bytes after the address and discards their values.
- R4: Every later write byte is acknowledged and stored in order into register 0, 1, 2 and so on, beginning at register 0 in each transaction.
- R5: The fields decode as follows. In register 0, bit 3 is freqSwSel, bit 1 is spreadEn, and tableIdx = {bit0, bit2, bits 7:4}. Register 1 is cpuEn and register 2 is pciEn. In register 3, bits 7:5 are fastEn, bit 3 is spreadWide and bit 2 is allTristate. auxEn = register 4 bits {7,6,4,3,2}. skewCode is register 5 bits 7:5. In register 9, bit 7 is nVal[8], bits 6:5 are divCode (00 = /2, 01 = /1.5, 10 = /1, 11 = /3) and bits 4:0 are mVal. Register 10 is nVal[7:0] and register 12 bit 7 is mnSel.
- R6: Registers 6 and 7 always read back as ID_HI (default 8'h90) and ID_LO (default 8'h21). Writes to them are acknowledged and have no effect.
- R7: A STOP or a repeated START ends a write at any byte. Registers already written keep their new values, and the rest keep their old values.
- R8: Write bytes beyond register 12 are acknowledged and discarded; they do not wrap around to register 0.
- R9: After a read address, the slave sends register 0, 1, ... MSB first. It continues while the master acknowledges, returns 8'hFF past register 12, and releases SDA after a not-acknowledge.
- R10: No bus activity restores defaults. A START, an address-only transaction and a STOP leave all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Active-low power-up reset, loads defaults |
| sclIn | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| sdaLowOut | output | 1 | 1 pulls SDA low (open drain) |
| freqSwSel | output | 1 | 0 = frequency from pins, 1 = from tableIdx |
| tableIdx | output | 6 | Software frequency table index |
| spreadEn | output | 1 | Spread spectrum enable |
| spreadWide | output | 1 | Spread depth: 0 = ±0.25 %, 1 = ±0.5 % |
| allTristate | output | 1 | Tristate all clock outputs |
| cpuEn | output | 8 | Enables of the processor-side clock group |
| pciEn | output | 8 | Enables of the first bus clock group |
| fastEn | output | 3 | Enables of the 66 MHz-class outputs |
| auxEn | output | 5 | Enables of the fixed and extra bus outputs |
| skewCode | output | 3 | Skew from CPU to the 66 MHz-class outputs |
| divCode | output | 2 | Divisor from CPU to the 66 MHz-class outputs |
| mnSel | output | 1 | 0 = table, 1 = M/N programming |
| nVal | output | 9 | N value |
| mVal | output | 5 | M value |

## Verification
The SCL and SDA edges reach the control logic two clocks late, through the synchronizers. The control registers its strobe one clock later, and the register file updates on the clock after that. A stored byte therefore reaches the field outputs four clock edges after the SCL fall that opens its acknowledge clock. The slave's SDA drive follows each SCL fall three clocks later. The bench holds every SCL phase for eight clocks. It samples the acknowledge and read bits in the middle of the SCL high phase, and reads the field outputs only after the STOP, so every result is settled when it is sampled.

// File: rtl/clkCfgPkg.sv
package clkCfgPkg;

  localparam int NUM_REGS = 13;
  localparam int PTR_W = $clog2(NUM_REGS + 1);

  // single-cycle requests from the bus control to the register file
  typedef struct packed {
    logic       ptrClr;
    logic       ptrInc;
    logic       wrStb;
    logic [7:0] wrData;
  } cfgStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKOUT,
    ST_TX,
    ST_ACKIN,
    ST_SKIP
  } linkState_t;

  function automatic logic [7:0] regDefault(input int idx,
                                            input logic [7:0] idHi,
                                            input logic [7:0] idLo);
    case (idx)
      1, 2, 4, 11: regDefault = 8'hFF;
      3:           regDefault = 8'hE0;
      5:           regDefault = 8'h9F;
      6:           regDefault = idHi;
      7:           regDefault = idLo;
      12:          regDefault = 8'h7F;
      default:     regDefault = 8'h00;
    endcase
  endfunction

  function automatic logic regWritable(input int idx);
    regWritable = (idx != 6) && (idx != 7);
  endfunction

endpackage

// File: rtl/i2cLinkCtrl.sv
module i2cLinkCtrl
  import clkCfgPkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h5A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdByte,
  output cfgStrobe_t strobe,
  output logic       sdaLow
);

  logic [1:0] sclSync, sdaSync;
  logic       sclQ, sdaQ;
  logic       sclS, sdaS;
  logic       startSeen, stopSeen, sclRise, sclFall;

  linkState_t state;
  logic [3:0] bitCnt;
  logic [1:0] byteNo;
  logic [7:0] rxShift, txShift;
  logic       isRead, mAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclQ    <= sclSync[1];
      sdaQ    <= sdaSync[1];
    end
  end

  assign sclS      = sclSync[1];
  assign sdaS      = sdaSync[1];
  assign startSeen = sclS && sclQ && sdaQ && !sdaS;
  assign stopSeen  = sclS && sclQ && !sdaQ && sdaS;
  assign sclRise   = sclS && !sclQ;
  assign sclFall   = !sclS && sclQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      byteNo  <= '0;
      rxShift <= '0;
      txShift <= '0;
      isRead  <= 1'b0;
      mAck    <= 1'b0;
      strobe  <= '0;
    end else begin
      strobe <= '0;
      if (startSeen) begin
        state  <= ST_RX;
        bitCnt <= '0;
        byteNo <= '0;
      end else if (stopSeen) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise) begin
              rxShift <= {rxShift[6:0], sdaS};
              bitCnt  <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              if (byteNo == 2'd0) begin
                if (rxShift[7:1] == SLAVE_ADDR) begin
                  isRead        <= rxShift[0];
                  strobe.ptrClr <= 1'b1;
                  byteNo        <= 2'd1;
                  state         <= ST_ACKOUT;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                if (byteNo == 2'd3 && !isRead) begin
                  strobe.wrStb  <= 1'b1;
                  strobe.ptrInc <= 1'b1;
                  strobe.wrData <= rxShift;
                end else begin
                  byteNo <= byteNo + 2'd1;
                end
                state <= ST_ACKOUT;
              end
            end
          end
          ST_ACKOUT: begin
            if (sclFall) begin
              if (isRead) begin
                txShift       <= rdByte;
                strobe.ptrInc <= 1'b1;
                bitCnt        <= '0;
                state         <= ST_TX;
              end else begin
                state <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                bitCnt <= '0;
                state  <= ST_ACKIN;
              end else begin
                txShift <= {txShift[6:0], 1'b1};
              end
            end
          end
          ST_ACKIN: begin
            if (sclRise) begin
              mAck <= !sdaS;
            end else if (sclFall) begin
              if (mAck) begin
                txShift       <= rdByte;
                strobe.ptrInc <= 1'b1;
                state         <= ST_TX;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaLow = (state == ST_ACKOUT) || (state == ST_TX && !txShift[7]);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaLow); // R1
  AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !sdaLow); // R2
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (state == ST_IDLE && !sdaLow)); // R7
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> (state == ST_RX && byteNo == 2'd0)); // R7
  AST_WRITE_AFTER_FILLERS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrStb |-> (byteNo == 2'd3 && !isRead)); // R3

endmodule

// File: rtl/cfgRegBank.sv
module cfgRegBank
  import clkCfgPkg::*;
#(
  parameter logic [7:0] ID_HI = 8'h90,
  parameter logic [7:0] ID_LO = 8'h21
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfgStrobe_t strobe,
  output logic [7:0] rdByte,
  output logic       freqSwSel,
  output logic [5:0] tableIdx,
  output logic       spreadEn,
  output logic       spreadWide,
  output logic       allTristate,
  output logic [7:0] cpuEn,
  output logic [7:0] pciEn,
  output logic [2:0] fastEn,
  output logic [4:0] auxEn,
  output logic [2:0] skewCode,
  output logic [1:0] divCode,
  output logic       mnSel,
  output logic [8:0] nVal,
  output logic [4:0] mVal
);

  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

  logic [7:0]       regFile [NUM_REGS];
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobe.ptrClr) begin
      ptr <= '0;
    end else if (strobe.ptrInc && ptr != PTR_END) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= regDefault(i, ID_HI, ID_LO);
    end else if (strobe.wrStb && ptr != PTR_END && regWritable(int'(ptr))) begin
      regFile[ptr] <= strobe.wrData;
    end
  end

  assign rdByte = (ptr == PTR_END) ? 8'hFF : regFile[ptr];

  assign freqSwSel   = regFile[0][3];
  assign tableIdx    = {regFile[0][0], regFile[0][2], regFile[0][7:4]};
  assign spreadEn    = regFile[0][1];
  assign cpuEn       = regFile[1];
  assign pciEn       = regFile[2];
  assign fastEn      = regFile[3][7:5];
  assign spreadWide  = regFile[3][3];
  assign allTristate = regFile[3][2];
  assign auxEn       = {regFile[4][7:6], regFile[4][4:2]};
  assign skewCode    = regFile[5][7:5];
  assign nVal        = {regFile[9][7], regFile[10]};
  assign divCode     = regFile[9][6:5];
  assign mVal        = regFile[9][4:0];
  assign mnSel       = regFile[12][7];

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= PTR_END); // R8
  AST_FIRST_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStb && ptr == '0) |=> (regFile[0] == $past(strobe.wrData))); // R4
  AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStb && ptr == PTR_W'(6)) |=> (rdByte != 8'hFF || ID_LO == 8'hFF || ptr != PTR_W'(7))); // R6

endmodule

// File: rtl/clkCfgSlave.sv
module clkCfgSlave
  import clkCfgPkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h5A,
  parameter logic [7:0] ID_HI      = 8'h90,
  parameter logic [7:0] ID_LO      = 8'h21
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaLowOut,
  output logic       freqSwSel,
  output logic [5:0] tableIdx,
  output logic       spreadEn,
  output logic       spreadWide,
  output logic       allTristate,
  output logic [7:0] cpuEn,
  output logic [7:0] pciEn,
  output logic [2:0] fastEn,
  output logic [4:0] auxEn,
  output logic [2:0] skewCode,
  output logic [1:0] divCode,
  output logic       mnSel,
  output logic [8:0] nVal,
  output logic [4:0] mVal
);

  cfgStrobe_t strobe;
  logic [7:0] rdByte;

  i2cLinkCtrl #(.SLAVE_ADDR(SLAVE_ADDR)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .rdByte (rdByte),
    .strobe (strobe),
    .sdaLow (sdaLowOut)
  );

  cfgRegBank #(.ID_HI(ID_HI), .ID_LO(ID_LO)) uBank (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rdByte      (rdByte),
    .freqSwSel   (freqSwSel),
    .tableIdx    (tableIdx),
    .spreadEn    (spreadEn),
    .spreadWide  (spreadWide),
    .allTristate (allTristate),
    .cpuEn       (cpuEn),
    .pciEn       (pciEn),
    .fastEn      (fastEn),
    .auxEn       (auxEn),
    .skewCode    (skewCode),
    .divCode     (divCode),
    .mnSel       (mnSel),
    .nVal        (nVal),
    .mVal        (mVal)
  );

endmodule

// File: tb/clkCfgSlave_test.sv
module clkCfgSlave_test;

  localparam logic [6:0] ADDR = 7'h5A;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic sdaLine;
  logic sdaLowOut, freqSwSel, spreadEn, spreadWide, allTristate, mnSel;
  logic [5:0] tableIdx;
  logic [7:0] cpuEn, pciEn;
  logic [2:0] fastEn, skewCode;
  logic [4:0] auxEn, mVal;
  logic [1:0] divCode;
  logic [8:0] nVal;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  assign sdaLine = mSda & ~sdaLowOut;

  clkCfgSlave uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaLowOut(sdaLowOut),
    .freqSwSel(freqSwSel), .tableIdx(tableIdx), .spreadEn(spreadEn),
    .spreadWide(spreadWide), .allTristate(allTristate), .cpuEn(cpuEn),
    .pciEn(pciEn), .fastEn(fastEn), .auxEn(auxEn), .skewCode(skewCode),
    .divCode(divCode), .mnSel(mnSel), .nVal(nVal), .mVal(mVal)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; tick(H);
    scl = 1'b1;  tick(H);
    mSda = 1'b0; tick(H);
    scl = 1'b0;  tick(H);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(H);
    scl = 1'b1;  tick(H);
    mSda = 1'b1; tick(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; tick(H);
      scl = 1'b1;  tick(H);
      scl = 1'b0;  tick(2);
    end
    mSda = 1'b1; tick(H);
    scl = 1'b1;  tick(H / 2);
    ack = !sdaLine;
    tick(H / 2);
    scl = 1'b0;  tick(2);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl = 1'b1; tick(H / 2);
      b[i] = sdaLine;
      tick(H / 2);
      scl = 1'b0; tick(2);
    end
    mSda = !ackIt; tick(H);
    scl = 1'b1;    tick(H);
    scl = 1'b0;    tick(2);
    mSda = 1'b1;
  endtask

  task automatic testReset();
    chk("R1", "sdaLowOut", int'(sdaLowOut), 0);
    chk("R1", "freqSwSel", int'(freqSwSel), 0);
    chk("R1", "tableIdx", int'(tableIdx), 0);
    chk("R1", "spread", int'({spreadEn, spreadWide, allTristate}), 0);
    chk("R1", "cpuEn", int'(cpuEn), 8'hFF);
    chk("R1", "pciEn", int'(pciEn), 8'hFF);
    chk("R1", "fastEn", int'(fastEn), 7);
    chk("R1", "auxEn", int'(auxEn), 5'h1F);
    chk("R1", "skewCode", int'(skewCode), 4);
    chk("R1", "div/mn", int'({divCode, mnSel, nVal, mVal}), 0);
  endtask

  task automatic testFill();
    logic [7:0] wv [15];
    logic ack;
    wv = '{8'hBD, 8'h5A, 8'hC3, 8'h5C, 8'h94, 8'h60, 8'h00, 8'hFF,
           8'h3C, 8'hCB, 8'h37, 8'h12, 8'h80, 8'h00, 8'h00};
    busStart();
    sendByte({ADDR, 1'b0}, ack); chk("R2", "addr ack", int'(ack), 1);
    sendByte(8'hAA, ack);        chk("R3", "cmd filler ack", int'(ack), 1);
    sendByte(8'h55, ack);        chk("R3", "count filler ack", int'(ack), 1);
    for (int i = 0; i < 15; i++) begin
      sendByte(wv[i], ack);
      chk(i < 13 ? "R4" : "R8", $sformatf("data ack %0d", i), int'(ack), 1);
    end
    busStop();
    chk("R5", "freqSwSel", int'(freqSwSel), 1);
    chk("R5", "tableIdx", int'(tableIdx), 6'h3B);
    chk("R5", "spreadEn", int'(spreadEn), 0);
    chk("R4", "cpuEn", int'(cpuEn), 8'h5A);
    chk("R4", "pciEn", int'(pciEn), 8'hC3);
    chk("R5", "fastEn", int'(fastEn), 3'b010);
    chk("R5", "spreadWide", int'(spreadWide), 1);
    chk("R5", "allTristate", int'(allTristate), 1);
    chk("R5", "auxEn", int'(auxEn), 5'b10101);
    chk("R5", "skewCode", int'(skewCode), 3'b011);
    chk("R5", "divCode", int'(divCode), 2'b10);
    chk("R5", "mVal", int'(mVal), 5'h0B);
    chk("R5", "nVal", int'(nVal), 9'h137);
    chk("R5", "mnSel", int'(mnSel), 1);
  endtask

  task automatic testReadBack();
    logic [7:0] ev [14];
    logic [7:0] v;
    logic ack;
    ev = '{8'hBD, 8'h5A, 8'hC3, 8'h5C, 8'h94, 8'h60, 8'h90, 8'h21,
           8'h3C, 8'hCB, 8'h37, 8'h12, 8'h80, 8'hFF};
    busStart();
    sendByte({ADDR, 1'b1}, ack); chk("R9", "read addr ack", int'(ack), 1);
    for (int i = 0; i < 14; i++) begin
      recvByte(i < 13, v);
      chk((i == 6 || i == 7) ? "R6" : "R9", $sformatf("read reg %0d", i), int'(v), int'(ev[i]));
    end
    tick(H);
    chk("R9", "released after nack", int'(sdaLowOut), 0);
    busStop();
  endtask

  task automatic testBadAddr();
    logic ack;
    busStart();
    sendByte({ADDR ^ 7'h01, 1'b0}, ack); chk("R2", "wrong addr nack", int'(ack), 0);
    sendByte(8'h00, ack);
    sendByte(8'h00, ack);
    sendByte(8'h00, ack); chk("R2", "skip data nack", int'(ack), 0);
    busStop();
    chk("R2", "tableIdx untouched", int'(tableIdx), 6'h3B);
    chk("R2", "cpuEn untouched", int'(cpuEn), 8'h5A);
  endtask

  task automatic testNoReset();
    logic ack;
    busStart();
    sendByte({ADDR, 1'b0}, ack);
    busStop();
    chk("R10", "tableIdx kept", int'(tableIdx), 6'h3B);
    chk("R10", "skewCode kept", int'(skewCode), 3'b011);
    chk("R10", "nVal kept", int'(nVal), 9'h137);
  endtask

  task automatic testPartial();
    logic ack;
    logic [7:0] v;
    busStart();
    sendByte({ADDR, 1'b0}, ack);
    sendByte(8'h11, ack);
    sendByte(8'h22, ack);
    sendByte(8'h02, ack);
    sendByte(8'h00, ack);
    busStart();
    sendByte({ADDR, 1'b1}, ack); chk("R7", "restart addr ack", int'(ack), 1);
    recvByte(1'b1, v); chk("R7", "reg0 new", int'(v), 8'h02);
    recvByte(1'b1, v); chk("R7", "reg1 new", int'(v), 8'h00);
    recvByte(1'b0, v); chk("R7", "reg2 old", int'(v), 8'hC3);
    busStop();
    chk("R5", "spreadEn set", int'(spreadEn), 1);
    chk("R5", "freqSwSel clear", int'(freqSwSel), 0);
    chk("R7", "cpuEn new", int'(cpuEn), 0);
    chk("R7", "fastEn old", int'(fastEn), 3'b010);
  endtask

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(5);
    testReset();
    testFill();
    testReadBack();
    testBadAddr();
    testNoReset();
    testPartial();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule